// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a base clock. Software controls it through one 16-bit clock-control halfword. The halfword has an internal-clock enable, a read-only internal-clock-stable flag, a card-clock enable and a divisor field. In the wide mode, the divisor field also has a two-bit upper extension. The divisor field holds half of the divide ratio.

A strap input selects the encoding of the divisor field:

- **Legacy (narrow) mode:** the field holds a power-of-two half ratio. The ratio can be 1 to 256.
- **Wide mode:** the ten-bit half ratio allows 1 or any even ratio up to 2046.

A field value of zero passes the base clock through undivided.

Software uses the block in a fixed order:

1. Clear both enables.
2. Program the divisor.
3. Set the internal enable.
4. Poll the stable flag.
5. Set the card enable.

The block also tolerates deviations from this order. It captures the divisor only while the internal enable is off. It moves the card gate only when the divided clock is low, so the card pin never sees a shortened high phase. A one-cycle qualifier marks each rising card-clock edge, so logic downstream can stay in the base-clock domain.

Top module: `sdcard_clk_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the read-back is 0x0000, and card_clk and card_clk_rise are 0.
- R2: The read-back layout is as follows:
  - Bits 15:8 are the low divisor field.
  - Bits 7:6 are the upper divisor bits.
  - Bit 2 is the card-clock enable.
  - Bit 1 is the stable flag.
  - Bit 0 is the internal-clock enable.
  - Bits 5:3 read 0.
  - Writes to bits 5:1 other than bit 2 are ignored.
- R3: The stable flag reads 1 exactly STABLE_CYCLES (default 16) base-clock edges after the edge that set the internal enable. It reads 0 from the same edge that clears the internal enable.
- R4: With a half ratio of 0 and both enables set, card_clk follows the base clock and card_clk_rise is held at 1.
- R5: In wide mode (ver_wide=1), the half ratio is N = {bits 7:6, bits 15:8}. For N ≥ 1, card_clk is high for N base cycles and then low for N base cycles.
- R6: In narrow mode (ver_wide=0), the half ratio is bits 15:8. Bits 7:6 have no effect on the ratio.
- R7: In narrow mode, a divisor field with several bits set divides as if only its most significant set bit were present.
- R8: card_clk is 0 while the card enable or the stable flag is 0. The gate opens or closes only at an edge after which the divided clock is low, so every high phase lasts the full N cycles.
- R9: A divisor or strap change made while the internal enable is 1 shows in the read-back but does not change the running ratio. It takes effect after the internal enable has been cleared.
- R10: In divided mode, card_clk_rise is 1 for exactly the one base cycle in which card_clk has just risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ver_wide | input | 1 | Strap: 1 selects the 10-bit divisor mode, 0 the 8-bit power-of-two mode |
| reg_wr_en | input | 1 | Write strobe for the clock-control halfword |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Read-back of the clock-control halfword, including the stable flag |
| card_clk | output | 1 | Gated, divided card clock |
| card_clk_rise | output | 1 | One-base-cycle qualifier at each rising card_clk edge |

## Verification
The hardest situation to reach is a card-enable change that lands in the middle of a high phase, since the gate must wait for the low phase before it moves. The bench waits until card_clk is seen high and then clears the card enable on the next falling base edge, while its cycle model checks that the high phase still ends on schedule. A second hard case is a divisor rewrite while the divider runs. The bench issues this rewrite and then measures a full high phase to confirm the old ratio is still in use. The largest wide ratio (2046) is driven to cover the upper-bit concatenation at its limit.

// File: rtl/sdc_pkg.sv
// Shared definitions for the SD card clock divider.
// Assumes the register layout used by the top module: 8-bit low divisor,
// 2-bit upper divisor, one control bit per enable.
package sdc_pkg;

    localparam int unsigned LO_W   = 8;
    localparam int unsigned HI_W   = 2;
    localparam int unsigned HALF_W = LO_W + HI_W;

    // Keep only the most significant set bit of a narrow divisor field.
    function automatic logic [LO_W-1:0] keep_top_bit(input logic [LO_W-1:0] v);
        logic [LO_W-1:0] r;
        r = '0;
        for (int i = 0; i < int'(LO_W); i++) begin
            if (v[i]) r = LO_W'(1) << i;
        end
        return r;
    endfunction

    // Turn the register fields into the half ratio in effect for the selected mode.
    function automatic logic [HALF_W-1:0] half_ratio(input logic            wide,
                                                     input logic [HI_W-1:0] hi,
                                                     input logic [LO_W-1:0] lo);
        if (wide) return {hi, lo};
        return {{HI_W{1'b0}}, keep_top_bit(lo)};
    endfunction

endpackage

// File: rtl/sdc_ready_timer.sv
// Settle timer: raises ready SETTLE edges after run goes high, and drops it
// combinationally as soon as run is low. Assumes SETTLE >= 1.
module sdc_ready_timer #(
    parameter int unsigned SETTLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ready
);
    localparam int unsigned CW = $clog2(SETTLE + 1);

    logic [CW-1:0] cnt;

    // Count base cycles while running, saturating at SETTLE.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)            cnt <= '0;
        else if (cnt != CW'(SETTLE))   cnt <= cnt + 1'b1;
    end

    assign ready = run && (cnt == CW'(SETTLE));

endmodule

// File: rtl/sdc_toggle_div.sv
// Even divider: toggles div_q every HALF base cycles while run is high, giving
// a 50% duty clock of ratio 2*HALF. Held low and cleared when run is low.
// Assumes half != 0 whenever run is high and half is stable while running.
module sdc_toggle_div #(
    parameter int unsigned DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] half,
    output logic          div_q,
    output logic          div_next
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] cnt_next;

    // Next-state of the phase counter and the toggle output.
    always_comb begin
        cnt_next = cnt + 1'b1;
        div_next = div_q;
        if (!run) begin
            cnt_next = '0;
            div_next = 1'b0;
        end else if (cnt == half - 1'b1) begin
            cnt_next = '0;
            div_next = ~div_q;
        end
    end

    // Phase counter and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_next;
            div_q <= div_next;
        end
    end

endmodule

// File: rtl/sdc_out_gate.sv
// Output stage: gates the divided clock to the card pin, moving the gate only
// when the divided clock will be low; in bypass it ANDs the base clock with
// an enable captured on the falling edge. Produces the rising-edge qualifier.
// Assumes bypass only changes while open_req is low.
module sdc_out_gate (
    input  logic clk_base,
    input  logic rst_n,
    input  logic bypass,
    input  logic open_req,
    input  logic div_q,
    input  logic div_next,
    output logic card_clk,
    output logic card_clk_rise
);
    logic gate_q;
    logic gate_neg;
    logic rise_q;

    // Move the divided-path gate only at edges leaving the clock low.
    always_ff @(posedge clk_base) begin
        if (!rst_n)         gate_q <= 1'b0;
        else if (!div_next) gate_q <= open_req;
    end

    // Flag the cycle right after a gated rising edge of the divided clock.
    always_ff @(posedge clk_base) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= div_next & ~div_q & gate_q;
    end

    // Bypass enable changes only while the base clock is low.
    always_ff @(negedge clk_base) begin
        if (!rst_n) gate_neg <= 1'b0;
        else        gate_neg <= bypass & open_req;
    end

    assign card_clk      = bypass ? (clk_base & gate_neg) : (div_q & gate_q);
    assign card_clk_rise = bypass ? gate_neg : rise_q;

endmodule

// File: rtl/sdcard_clk_gen.sv
// SD card clock generator: clock-control halfword, divisor capture, settle
// timer, divider and glitch-free output gate.
// Assumes the divisor is captured only while the internal enable is off.
module sdcard_clk_gen #(
    parameter int unsigned STABLE_CYCLES = 16
) (
    input  logic        clk_base,
    input  logic        rst_n,
    input  logic        ver_wide,
    input  logic        reg_wr_en,
    input  logic [15:0] reg_wr_data,
    output logic [15:0] reg_rd_data,
    output logic        card_clk,
    output logic        card_clk_rise
);
    import sdc_pkg::*;

    localparam int unsigned ICE_BIT = 0;
    localparam int unsigned CCE_BIT = 2;
    localparam int unsigned HI_LSB  = 6;
    localparam int unsigned LO_LSB  = 8;

    logic              ice_q;
    logic              cce_q;
    logic [LO_W-1:0]   lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [HALF_W-1:0] half_q;
    logic              wide_q;
    logic              stable;
    logic              bypass;
    logic              div_q;
    logic              div_next;
    logic [LO_W-1:0]   lo_in;
    logic [HI_W-1:0]   hi_in;

    // Register fields as they will read after this edge.
    always_comb begin
        lo_in = reg_wr_en ? reg_wr_data[LO_LSB +: LO_W] : lo_q;
        hi_in = reg_wr_en ? reg_wr_data[HI_LSB +: HI_W] : hi_q;
    end

    // Software-visible control fields.
    always_ff @(posedge clk_base) begin
        if (!rst_n) begin
            ice_q <= 1'b0;
            cce_q <= 1'b0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (reg_wr_en) begin
            ice_q <= reg_wr_data[ICE_BIT];
            cce_q <= reg_wr_data[CCE_BIT];
            lo_q  <= lo_in;
            hi_q  <= hi_in;
        end
    end

    // Capture the effective half ratio and mode only while the divider is off.
    always_ff @(posedge clk_base) begin
        if (!rst_n) begin
            half_q <= '0;
            wide_q <= 1'b0;
        end else if (!ice_q) begin
            half_q <= half_ratio(ver_wide, hi_in, lo_in);
            wide_q <= ver_wide;
        end
    end

    assign bypass = (half_q == '0);

    sdc_ready_timer #(.SETTLE(STABLE_CYCLES)) u_timer (
        .clk   (clk_base),
        .rst_n (rst_n),
        .run   (ice_q),
        .ready (stable)
    );

    sdc_toggle_div #(.DW(HALF_W)) u_div (
        .clk      (clk_base),
        .rst_n    (rst_n),
        .run      (ice_q & ~bypass),
        .half     (half_q),
        .div_q    (div_q),
        .div_next (div_next)
    );

    sdc_out_gate u_gate (
        .clk_base      (clk_base),
        .rst_n         (rst_n),
        .bypass        (bypass),
        .open_req      (cce_q & stable),
        .div_q         (div_q),
        .div_next      (div_next),
        .card_clk      (card_clk),
        .card_clk_rise (card_clk_rise)
    );

    assign reg_rd_data = {lo_q, hi_q, 3'b000, cce_q, stable, ice_q};

endmodule

// File: rtl/sdc_clk_chk.sv
// Property checker for sdcard_clk_gen, attached by bind.
module sdc_clk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] rd,
    input logic        rise,
    input logic        bypass,
    input logic [9:0]  half,
    input logic        wide
);
    // R3
    stable_needs_ice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd[0] |-> !rd[1]);

    // R3
    stable_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd[1]) |-> ($past(rd[0]) && rd[0]));

    // R8
    rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(rd[0]));

    // R10
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !bypass && $stable(bypass)) |=> !rise);

    // R7
    narrow_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> $onehot0(half));
endmodule

bind sdcard_clk_gen sdc_clk_chk i_chk (
    .clk    (clk_base),
    .rst_n  (rst_n),
    .rd     (reg_rd_data),
    .rise   (card_clk_rise),
    .bypass (bypass),
    .half   (half_q),
    .wide   (wide_q)
);

// File: tb/test_sdcard_clk_gen.sv
`timescale 1ns/1ps
module test_sdcard_clk_gen;
    localparam int S = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ver_wide = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic        card_clk;
    logic        card_clk_rise;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sdcard_clk_gen #(.STABLE_CYCLES(S)) i_sdcard_clk_gen (
        .clk_base (clk), .rst_n (rst_n), .ver_wide (ver_wide),
        .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data), .card_clk (card_clk),
        .card_clk_rise (card_clk_rise)
    );

    // Behavioural reference model
    bit m_ice, m_cce, m_div, m_gate, m_card_prev;
    bit [7:0] m_lo;
    bit [1:0] m_hi;
    int m_s, m_t, m_n;
    bit e_card, e_rise;
    bit [15:0] e_rd;

    function automatic int model_half(bit wide, bit [1:0] hi, bit [7:0] lo);
        int p;
        if (wide) return hi * 256 + lo;
        p = 0;
        for (int v = 1; v <= 128; v = v * 2) if (lo >= v) p = v;
        return p;
    endfunction

    task automatic report_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        bit old_ice, old_cce, old_st, byp_exp, card_div, st_new;
        cycles++;
        if (cycles > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog %s got hang expected finish", cur_req);
            report_end();
        end
        if (!rst_n) begin
            m_ice = 0; m_cce = 0; m_div = 0; m_gate = 0; m_card_prev = 0;
            m_lo = 0; m_hi = 0; m_s = 0; m_t = 0; m_n = 0;
            e_card = 0; e_rise = 0; e_rd = 0;
        end else begin
            old_ice = m_ice; old_cce = m_cce;
            old_st  = m_ice && (m_s == S);
            byp_exp = old_ice && old_cce && old_st;
            if (reg_wr_en) begin
                m_ice = reg_wr_data[0]; m_cce = reg_wr_data[2];
                m_hi = reg_wr_data[7:6]; m_lo = reg_wr_data[15:8];
            end
            m_s = old_ice ? ((m_s < S) ? m_s + 1 : S) : 0;
            if (old_ice && m_n != 0) begin
                m_t++;
                m_div = ((m_t / m_n) % 2) == 1;
            end else begin
                m_t = 0; m_div = 0;
            end
            if (!m_div) m_gate = old_cce && old_st;
            if (!old_ice) m_n = model_half(ver_wide, m_hi, m_lo);
            card_div = m_div && m_gate;
            st_new = m_ice && (m_s == S);
            e_card = (m_n == 0) ? byp_exp : card_div;
            e_rise = (m_n == 0) ? byp_exp : (card_div && !m_card_prev);
            m_card_prev = card_div;
            e_rd = {m_lo, m_hi, 3'b000, m_cce, st_new, m_ice};
        end
    end

    // Cycle-by-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            checks++;
            if (card_clk !== e_card || card_clk_rise !== e_rise || reg_rd_data !== e_rd) begin
                errors++;
                $display("FAIL %s cycle %0d got clk=%b rise=%b rd=%h expected clk=%b rise=%b rd=%h",
                         cur_req, cycles, card_clk, card_clk_rise, reg_rd_data,
                         e_card, e_rise, e_rd);
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic high_run(input string req, input int exp_len);
        int len;
        bit seen;
        seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(posedge clk); #2; if (!card_clk) seen = 1;
        end
        seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(posedge clk); #2; if (card_clk) seen = 1;
        end
        len = 1;
        for (int i = 0; i < 5000 && card_clk; i++) begin
            @(posedge clk); #2; if (card_clk) len++;
        end
        check(req, len, exp_len);
    endtask

    task automatic count_high(input string req, input int n, input int exp_cnt, input bit rises);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            if (rises ? card_clk_rise : card_clk) c++;
        end
        check(req, c, exp_cnt);
    endtask

    initial begin
        int k;
        idle(4);
        // R1: reset state
        check("R1", reg_rd_data, 0);
        check("R1", card_clk, 0);
        check("R1", card_clk_rise, 0);
        rst_n = 1'b1;
        idle(2);

        // R2: layout, reserved bits and stable flag not writable
        cur_req = "R2";
        wr(16'hA5C6); check("R2", reg_rd_data, 16'hA5C4);
        wr(16'hFF3E); check("R2", reg_rd_data, 16'hFF04);
        wr(16'h0000);

        // R3: stable timing, wide N=3, card enable off
        cur_req = "R3";
        wr(16'h0301);
        k = 0;
        for (int i = 1; i <= 40 && k == 0; i++) begin
            @(posedge clk); #1; if (reg_rd_data[1]) k = i;
        end
        check("R3", k, S);

        // R8: card enable off keeps the pin low
        cur_req = "R8";
        count_high("R8", 20, 0, 0);

        // R5 / R10: divided output
        cur_req = "R5";
        wr(16'h0305);
        high_run("R5", 3);
        cur_req = "R10";
        idle(1);
        count_high("R10", 60, 10, 1);

        // R9: divisor rewrite while running has no effect yet
        cur_req = "R9";
        wr(16'h0505);
        check("R9", reg_rd_data[15:8], 5);
        high_run("R9", 3);

        // R8: drop card enable in the middle of a high phase
        cur_req = "R8";
        k = 0;
        for (int i = 0; i < 20 && k == 0; i++) begin
            @(posedge clk); #1; if (card_clk) k = 1;
        end
        wr(16'h0501);
        idle(8);
        count_high("R8", 40, 0, 0);

        // R3: stable clears with the internal enable
        cur_req = "R3";
        wr(16'h0000);
        check("R3", reg_rd_data[1], 0);
        idle(2);

        // R5: largest wide ratio 2046
        cur_req = "R5";
        wr(16'hFFC0); wr(16'hFFC5);
        high_run("R5", 1023);
        wr(16'h0000); idle(2);

        // R4: bypass
        cur_req = "R4";
        wr(16'h0005);
        idle(S + 4);
        @(posedge clk); #1;
        check("R4", card_clk, 1);
        check("R4", card_clk_rise, 1);
        @(negedge clk); #1;
        check("R4", card_clk, 0);
        wr(16'h0000); idle(2);

        // R6: narrow mode, upper bits ignored
        cur_req = "R6";
        @(negedge clk); ver_wide = 1'b0;
        wr(16'h10C5);
        high_run("R6", 16);
        wr(16'h0000); idle(2);

        // R7: narrow mode, several bits set
        cur_req = "R7";
        wr(16'h2C05);
        high_run("R7", 32);
        wr(16'h0000); idle(4);

        report_end();
    end
endmodule